// File: doc/BRIEF.md
# Latency-Aware Issue Interlock

This block decides, every cycle, whether the single instruction waiting at decode of an in-order pipeline may issue. The functional units produce results at different depths. So the wait a dependent instruction needs depends on two things: the class of the instruction that produced the operand, and the way the waiting instruction uses that operand. The block keeps a short countdown and a producer-class tag for every architectural register. It compares each live source against a per-pair slack and holds the decode slot until every source can be forwarded in time.

Decode presents one instruction with its class, an optional destination and up to two optional sources. The class codes are integer op = 0, load = 1, FP ALU op = 2 and store = 3. The use of each source follows from the class:
- The first source of an FP ALU op, and both of its sources, are FP-operand uses.
- The second source of a store is store data.
- Every other source is an integer use, which includes addresses.

While `out_stall` is high the decode stage must keep the same instruction on the inputs. Because only that one instruction is ever examined, nothing behind it can overtake it. One clock cycle counts as one slot of separation, whether the cycle carried an issued instruction or was idle.

Top module: `issue_interlock`

## Requirements
- R1: After reset no register has a pending result, so any instruction offered first issues with zero stall cycles.
- R2: A consumer that uses an FP ALU result as an FP operand issues no earlier than 4 cycles after the producer issued (3 cycles of separation).
- R3: An FP ALU result used as store data needs 2 cycles of separation.
- R4: A load result used as an FP operand needs 1 cycle of separation.
- R5: A load result used as store data, and an integer result used by an integer op, need 0 cycles of separation.
- R6: A load result used by an integer op, including as an address, needs 1 cycle of separation.
- R7: Register 0, as a source or as a destination, never causes a stall.
- R8: When an issuing instruction writes a register that still has a pending result, the new producer's latency replaces the old one.
- R9: `out_stall` and `out_issue` are never both high. Both are low when `in_valid` is low. While stalled, the offered instruction does not issue.
- R10: Separation is counted in clock cycles. Idle cycles and independent instructions between the producer and the consumer reduce the stall by the same amount.
- R11: A source whose enable is low creates no dependency. An instruction whose destination enable is low, or a store, leaves no pending result.
- R12: Replaying the vector-add loop gives exactly 12 stall cycles in the four-copy form that keeps each load, add and store adjacent. It gives 0 stall cycles in the rescheduled form.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | An instruction is offered at decode |
| in_class | input | 2 | 0 integer, 1 load, 2 FP ALU, 3 store |
| in_dst | input | RW | Destination register index |
| in_dst_we | input | 1 | Instruction writes in_dst |
| in_src_a | input | RW | First source register index |
| in_src_a_en | input | 1 | First source is read |
| in_src_b | input | RW | Second source register index (store data for stores) |
| in_src_b_en | input | 1 | Second source is read |
| out_issue | output | 1 | Offered instruction issues on this clock edge |
| out_stall | output | 1 | Offered instruction is held this cycle |

## Verification
A countdown that is loaded wrongly or never decrements shows up at the first dependent instruction. It appears as a stall count off by one or more cycles, or as a stall that never releases. A wrong class tag changes only certain producer/consumer pairs: for example, a load tagged as FP would stall a following store-data use that should issue at once. Every offered instruction is compared with an independent issue-time model, so each error becomes visible within a few cycles of the producer issuing.

// File: rtl/issue_interlock.sv
module issue_interlock #(
  parameter int NREG       = 32,
  parameter int LAT_FP_FP  = 3,
  parameter int LAT_FP_ST  = 2,
  parameter int LAT_FP_INT = 3,
  parameter int LAT_LD_FP  = 1,
  parameter int LAT_LD_ST  = 0,
  parameter int LAT_LD_INT = 1,
  parameter int LAT_IN_INT = 0,
  parameter int LAT_IN_FP  = 0,
  parameter int LAT_IN_ST  = 0,
  localparam int RW = $clog2(NREG)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          in_valid,
  input  logic [1:0]    in_class,
  input  logic [RW-1:0] in_dst,
  input  logic          in_dst_we,
  input  logic [RW-1:0] in_src_a,
  input  logic          in_src_a_en,
  input  logic [RW-1:0] in_src_b,
  input  logic          in_src_b_en,
  output logic          out_issue,
  output logic          out_stall
);
  localparam logic [1:0] C_INT = 2'd0, C_LD = 2'd1, C_FP = 2'd2, C_ST = 2'd3;
  localparam logic [1:0] U_INT = 2'd0, U_FP = 2'd1, U_ST = 2'd2;

  localparam int D_IN0 = (LAT_IN_INT > LAT_IN_FP) ? LAT_IN_INT : LAT_IN_FP;
  localparam int D_IN  = (D_IN0 > LAT_IN_ST) ? D_IN0 : LAT_IN_ST;
  localparam int D_LD0 = (LAT_LD_INT > LAT_LD_FP) ? LAT_LD_INT : LAT_LD_FP;
  localparam int D_LD  = (D_LD0 > LAT_LD_ST) ? D_LD0 : LAT_LD_ST;
  localparam int D_FP0 = (LAT_FP_INT > LAT_FP_FP) ? LAT_FP_INT : LAT_FP_FP;
  localparam int D_FP  = (D_FP0 > LAT_FP_ST) ? D_FP0 : LAT_FP_ST;
  localparam int D_A   = (D_IN > D_LD) ? D_IN : D_LD;
  localparam int D_ALL = (D_A > D_FP) ? D_A : D_FP;
  localparam int CW    = (D_ALL < 1) ? 1 : $clog2(D_ALL + 1);

  function automatic int lat_of(input logic [1:0] p, input logic [1:0] u);
    case (p)
      C_FP:    return (u == U_FP) ? LAT_FP_FP : (u == U_ST) ? LAT_FP_ST : LAT_FP_INT;
      C_LD:    return (u == U_FP) ? LAT_LD_FP : (u == U_ST) ? LAT_LD_ST : LAT_LD_INT;
      C_INT:   return (u == U_FP) ? LAT_IN_FP : (u == U_ST) ? LAT_IN_ST : LAT_IN_INT;
      default: return 0;
    endcase
  endfunction

  function automatic int depth_of(input logic [1:0] p);
    case (p)
      C_FP:    return D_FP;
      C_LD:    return D_LD;
      C_INT:   return D_IN;
      default: return 0;
    endcase
  endfunction

  function automatic logic [CW-1:0] slack_of(input logic [1:0] p, input logic [1:0] u);
    return CW'(depth_of(p) - lat_of(p, u));
  endfunction

  logic [CW-1:0] cnt  [NREG];
  logic [1:0]    pcls [NREG];

  logic [1:0] use_a, use_b;
  assign use_a = (in_class == C_FP) ? U_FP : U_INT;
  assign use_b = (in_class == C_ST) ? U_ST : (in_class == C_FP) ? U_FP : U_INT;

  logic rdy_a, rdy_b;
  assign rdy_a = !in_src_a_en || (in_src_a == '0) ||
                 (cnt[in_src_a] <= slack_of(pcls[in_src_a], use_a));
  assign rdy_b = !in_src_b_en || (in_src_b == '0) ||
                 (cnt[in_src_b] <= slack_of(pcls[in_src_b], use_b));

  assign out_issue = in_valid && rdy_a && rdy_b;
  assign out_stall = in_valid && !(rdy_a && rdy_b);

  logic       wr_en;
  logic [CW-1:0] wr_depth;
  assign wr_en    = out_issue && in_dst_we && (in_class != C_ST);
  assign wr_depth = CW'(depth_of(in_class));

  for (genvar g = 0; g < NREG; g++) begin : g_reg
    if (g == 0) begin : g_zero
      assign cnt[g]  = '0;
      assign pcls[g] = C_INT;
    end else begin : g_live
      always_ff @(posedge clk) begin
        if (!rst_n) begin
          cnt[g]  <= '0;
          pcls[g] <= C_INT;
        end else if (wr_en && in_dst == RW'(g)) begin
          cnt[g]  <= wr_depth;
          pcls[g] <= in_class;
        end else if (cnt[g] != '0) begin
          cnt[g]  <= cnt[g] - 1'b1;
        end
      end
    end
  end
endmodule

module issue_interlock_chk #(parameter int RW = 5) (
  input logic          clk,
  input logic          rst_n,
  input logic          in_valid,
  input logic [1:0]    in_class,
  input logic [RW-1:0] in_dst,
  input logic          in_dst_we,
  input logic [RW-1:0] in_src_a,
  input logic          in_src_a_en,
  input logic          in_src_b_en,
  input logic          out_issue,
  input logic          out_stall
);
  logic live;
  always_ff @(posedge clk) live <= rst_n;

  logic wrote_nz;
  assign wrote_nz = out_issue && in_dst_we && (in_dst != '0);

  assert_exclusive_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !(out_issue && out_stall));
  assert_idle_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |-> !(out_issue || out_stall));
  assert_r0_free_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_src_a == '0 && !in_src_b_en) |-> !out_stall);
  assert_fp_fp_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (live && $past(wrote_nz && in_class == 2'd2) && in_valid && in_class == 2'd2 &&
     in_src_a_en && in_src_a == $past(in_dst)) |-> out_stall);
  assert_fp_store_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (live && $past(wrote_nz && in_class == 2'd2) && in_valid && in_class == 2'd3 &&
     !in_src_b_en && in_src_a_en && in_src_a == $past(in_dst)) |-> out_stall);
  assert_load_fp_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (live && $past(wrote_nz && in_class == 2'd1) && in_valid && in_class == 2'd2 &&
     in_src_a_en && in_src_a == $past(in_dst)) |-> out_stall);
  assert_load_int_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (live && $past(wrote_nz && in_class == 2'd1) && in_valid && in_class == 2'd0 &&
     in_src_a_en && in_src_a == $past(in_dst)) |-> out_stall);
  assert_int_int_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (live && $past(wrote_nz && in_class == 2'd0) && in_valid && in_class == 2'd0 &&
     in_src_a_en && in_src_a == $past(in_dst) && !in_src_b_en) |-> !out_stall);
endmodule

bind issue_interlock issue_interlock_chk #(.RW(RW)) chk_i (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_class(in_class),
  .in_dst(in_dst), .in_dst_we(in_dst_we), .in_src_a(in_src_a),
  .in_src_a_en(in_src_a_en), .in_src_b_en(in_src_b_en),
  .out_issue(out_issue), .out_stall(out_stall));

// File: tb/issue_interlock_tb.sv
`timescale 1ns/1ps
module issue_interlock_tb_top;
  localparam logic [1:0] CI = 2'd0, CL = 2'd1, CF = 2'd2, CS = 2'd3;

  logic clk = 0, rst_n = 0;
  logic in_valid = 0, in_dst_we = 0, in_src_a_en = 0, in_src_b_en = 0;
  logic [1:0] in_class = 0;
  logic [4:0] in_dst = 0, in_src_a = 0, in_src_b = 0;
  logic out_issue, out_stall;

  issue_interlock dut_i (.*);

  always #2 clk = ~clk;

  int tests = 0, fails = 0, cyc = 0;
  always @(posedge clk) cyc <= rst_n ? cyc + 1 : 0;

  bit pend [32];
  int last_cyc [32];
  logic [1:0] last_cls [32];

  function automatic int lat(input logic [1:0] p, input logic [1:0] u);
    if (p == CF) return (u == 2'd1) ? 3 : (u == 2'd2) ? 2 : 3;
    if (p == CL) return (u == 2'd1) ? 1 : (u == 2'd2) ? 0 : 1;
    return 0;
  endfunction

  task automatic check(input string tag, input int act, input int exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk); rst_n = 0; in_valid = 0;
    repeat (2) @(negedge clk);
    rst_n = 1;
    for (int i = 0; i < 32; i++) pend[i] = 0;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin @(negedge clk); in_valid = 0; end
  endtask

  task automatic offer(input string tag, input logic [1:0] c, input logic [4:0] d,
                       input logic we, input logic [4:0] a, input logic ae,
                       input logic [4:0] b, input logic be, output int stalls);
    int need, start;
    logic [1:0] ua, ub;
    @(negedge clk);
    in_valid = 1; in_class = c; in_dst = d; in_dst_we = we;
    in_src_a = a; in_src_a_en = ae; in_src_b = b; in_src_b_en = be;
    start = cyc; need = cyc;
    ua = (c == CF) ? 2'd1 : 2'd0;
    ub = (c == CS) ? 2'd2 : (c == CF) ? 2'd1 : 2'd0;
    if (ae && a != 0 && pend[a] && last_cyc[a] + 1 + lat(last_cls[a], ua) > need)
      need = last_cyc[a] + 1 + lat(last_cls[a], ua);
    if (be && b != 0 && pend[b] && last_cyc[b] + 1 + lat(last_cls[b], ub) > need)
      need = last_cyc[b] + 1 + lat(last_cls[b], ub);
    stalls = 0;
    #1;
    while (out_stall && stalls < 20) begin
      check({tag, " no issue while stalled (R9)"}, out_issue, 0);
      stalls++;
      @(negedge clk); #1;
    end
    check({tag, " issue"}, out_issue, 1);
    check({tag, " stall cycles vs model"}, stalls, need - start);
    if (we && d != 0 && c != CS) begin
      pend[d] = 1; last_cyc[d] = cyc; last_cls[d] = c;
    end
  endtask

  task automatic t_reset();
    int s;
    do_reset();
    #1;
    check("R1 stall after reset", out_stall, 0);
    check("R9 idle issue low", out_issue, 0);
    offer("R1", CF, 5'd3, 1, 5'd7, 1, 5'd9, 1, s);
    check("R1 first instr stalls", s, 0);
  endtask

  task automatic t_pairs();
    int s;
    do_reset();
    offer("R2 prod", CF, 5'd4, 1, 5'd1, 1, 5'd2, 1, s);
    offer("R2 cons", CF, 5'd5, 1, 5'd4, 1, 5'd2, 1, s);
    check("R2 fp->fp", s, 3);
    offer("R3 prod", CF, 5'd6, 1, 5'd1, 1, 5'd2, 1, s);
    offer("R3 cons", CS, 5'd0, 0, 5'd1, 1, 5'd6, 1, s);
    check("R3 fp->store data", s, 2);
    offer("R4 prod", CL, 5'd8, 1, 5'd1, 1, 5'd0, 0, s);
    offer("R4 cons", CF, 5'd9, 1, 5'd8, 1, 5'd2, 1, s);
    check("R4 load->fp", s, 1);
    offer("R5 prod", CL, 5'd10, 1, 5'd1, 1, 5'd0, 0, s);
    offer("R5 cons", CS, 5'd0, 0, 5'd1, 1, 5'd10, 1, s);
    check("R5 load->store data", s, 0);
    offer("R5 iprod", CI, 5'd11, 1, 5'd1, 1, 5'd0, 0, s);
    offer("R5 icons", CI, 5'd12, 1, 5'd11, 1, 5'd11, 1, s);
    check("R5 int->int", s, 0);
    offer("R6 prod", CL, 5'd13, 1, 5'd1, 1, 5'd0, 0, s);
    offer("R6 cons", CL, 5'd14, 1, 5'd13, 1, 5'd0, 0, s);
    check("R6 load->address", s, 1);
  endtask

  task automatic t_r0_disabled();
    int s;
    do_reset();
    offer("R7 prod", CF, 5'd0, 1, 5'd1, 1, 5'd2, 1, s);
    offer("R7 cons", CF, 5'd3, 1, 5'd0, 1, 5'd0, 1, s);
    check("R7 reg0 no dependency", s, 0);
    offer("R11 prod", CF, 5'd5, 1, 5'd1, 1, 5'd2, 1, s);
    offer("R11 cons", CF, 5'd6, 1, 5'd5, 0, 5'd5, 0, s);
    check("R11 disabled sources", s, 0);
    idle(4);
    offer("R11 nowe", CF, 5'd7, 0, 5'd1, 1, 5'd2, 1, s);
    offer("R11 cons2", CF, 5'd8, 1, 5'd7, 1, 5'd2, 1, s);
    check("R11 no write enable", s, 0);
  endtask

  task automatic t_waw();
    int s;
    do_reset();
    offer("R8 old", CF, 5'd4, 1, 5'd1, 1, 5'd2, 1, s);
    offer("R8 new", CI, 5'd4, 1, 5'd1, 1, 5'd0, 0, s);
    offer("R8 cons", CF, 5'd5, 1, 5'd4, 1, 5'd2, 1, s);
    check("R8 newer producer wins", s, 0);
    offer("R8 old2", CI, 5'd6, 1, 5'd1, 1, 5'd0, 0, s);
    offer("R8 new2", CF, 5'd6, 1, 5'd1, 1, 5'd2, 1, s);
    offer("R8 cons2", CF, 5'd7, 1, 5'd6, 1, 5'd2, 1, s);
    check("R8 newer longer producer", s, 3);
  endtask

  task automatic t_spacing();
    int s;
    do_reset();
    offer("R10 prod", CF, 5'd4, 1, 5'd1, 1, 5'd2, 1, s);
    offer("R10 ind1", CI, 5'd20, 1, 5'd1, 1, 5'd0, 0, s);
    idle(1);
    offer("R10 cons", CF, 5'd5, 1, 5'd4, 1, 5'd2, 1, s);
    check("R10 two slots used", s, 1);
    offer("R10 prod2", CF, 5'd6, 1, 5'd1, 1, 5'd2, 1, s);
    idle(3);
    offer("R10 cons2", CF, 5'd7, 1, 5'd6, 1, 5'd2, 1, s);
    check("R10 three idle slots", s, 0);
  endtask

  task automatic t_loop();
    int s, tot;
    do_reset();
    tot = 0;
    for (int k = 0; k < 4; k++) begin
      offer("R12 ld", CL, 5'(16 + 2*k), 1, 5'd1, 1, 5'd0, 0, s); tot += s;
      offer("R12 add", CF, 5'(24 + k), 1, 5'(16 + 2*k), 1, 5'd15, 1, s); tot += s;
      offer("R12 sd", CS, 5'd0, 0, 5'd1, 1, 5'(24 + k), 1, s); tot += s;
    end
    offer("R12 sub", CI, 5'd1, 1, 5'd1, 1, 5'd0, 0, s); tot += s;
    check("R12 naive total stalls", tot, 12);
    idle(4);
    tot = 0;
    for (int k = 0; k < 4; k++) begin
      offer("R12 ld", CL, 5'(16 + k), 1, 5'd1, 1, 5'd0, 0, s); tot += s;
    end
    for (int k = 0; k < 4; k++) begin
      offer("R12 add", CF, 5'(24 + k), 1, 5'(16 + k), 1, 5'd15, 1, s); tot += s;
    end
    for (int k = 0; k < 3; k++) begin
      offer("R12 sd", CS, 5'd0, 0, 5'd1, 1, 5'(24 + k), 1, s); tot += s;
    end
    offer("R12 sub", CI, 5'd1, 1, 5'd1, 1, 5'd0, 0, s); tot += s;
    offer("R12 sd last", CS, 5'd0, 0, 5'd1, 1, 5'd27, 1, s); tot += s;
    check("R12 scheduled total stalls", tot, 0);
  endtask

  initial begin
    t_reset();
    t_pairs();
    t_r0_disabled();
    t_waw();
    t_spacing();
    t_loop();
    idle(2);
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    #(200000 * 4);
    tests++; fails++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule